// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a programmable interval timer. A 16-bit down-counter advances on every rising edge of the clock. A gate input qualifies the counter, and the channel drives one output pin whose waveform depends on the selected operating mode. A 6-bit control field picks the mode and the number system, either plain binary or four packed decimal digits. The count value arrives as two byte writes, low byte first. A status byte reports the output level, whether a written count is still waiting to be taken up, and the control field last written.

The channel supports six output behaviours. These are an interrupt-style terminal-count flag, a gate-triggered one-shot, a rate generator, a square-wave divider, and a strobe started either by software or by the gate. A surrounding timer would place several of these channels side by side and handle address decoding and channel selection.

Top module: `pit_chan`

## Requirements
- R1: Mode code 0. The edge that takes the high byte drives OUT low. The next edge loads the count, and OUT rises on the N-th counting edge after the load. OUT then stays high until a new count or a new control field is written.
- R2: In mode codes 0, 2, 3 and 4, every edge that samples GATE low leaves the counter unchanged. Counting resumes from the held value once GATE is high again.
- R3: Mode code 1. After a count is written, OUT stays high until an edge sees GATE rise. That edge loads the count and drives OUT low, and OUT returns high N edges later. A further GATE rise during the pulse reloads the count. A count written during the pulse does not change that pulse.
- R4: Mode code 2. The output repeats with a period of N clocks and is low for exactly one clock per period. The first low clock comes N edges after the load.
- R5: Mode code 3. The output repeats with a period of N clocks. It is high for the first ceil(N/2) clocks and low for the remaining floor(N/2).
- R6: Mode code 4. After the load, the N-th counting edge drives OUT low for exactly one clock, and OUT then stays high.
- R7: Mode code 5. A GATE rise loads the count, and N edges later OUT goes low for one clock. No further pulse occurs until the next GATE rise.
- R8: The mode field is control bits 3:1, and bit 3 is ignored when bit 2 is set. Codes 6 and 7 therefore act as codes 2 and 3.
- R9: When control bit 0 is set, the counter counts in four packed decimal digits. A loaded value of 0 counts 10000 clocks.
- R10: In binary counting, a loaded value of 0 counts 65536 clocks.
- R11: The status byte has OUT in bit 7. Bit 6 is set from the high-byte write until that count is loaded. Bits 5:0 repeat the last control field written. Reset clears the status byte and drives OUT low.
- R12: Count bytes alternate low then high. A control write restarts the sequence at the low byte. A count byte written in the same cycle as a control write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Gate: count enable or trigger, depending on mode |
| cw_we_i | input | 1 | Control field write strobe |
| cw_i | input | 6 | Control field: bit 0 decimal, bits 3:1 mode, bits 5:4 access (echoed only) |
| cnt_we_i | input | 1 | Count byte write strobe |
| cnt_byte_i | input | 8 | Count byte, low byte first, then high byte |
| out_o | output | 1 | Channel output |
| status_o | output | 8 | Status byte: OUT, count pending, control field |

## Verification
The bench targets three groups of corner cases. The first is the odd-length square wave: a design that rounds the half-period the wrong way gives a low phase one clock too long. The second is decimal counting across digit boundaries and from zero: a design that borrows in binary runs 256 clocks instead of 100, and 65536 instead of 10000. The third is a one-shot retriggered mid-pulse, and one that receives a new count mid-pulse: a wrong design either ends the pulse on the old schedule or changes it without a trigger. Gate suspension, the 6 and 7 mode aliases, and a byte pointer left half-way by a control write are each timed to the clock, so any slip of the output edge is caught.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    M_TCNT    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } pit_mode_e;

  // codes 6/7 fold onto 2/3
  function automatic pit_mode_e norm_mode(input logic [2:0] code);
    return code[1] ? pit_mode_e'({1'b0, code[1:0]}) : pit_mode_e'(code);
  endfunction
endpackage

// File: rtl/pit_cfg.sv
module pit_cfg
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cw_we_i,
  input  logic [5:0]            cw_i,
  input  logic                  cnt_we_i,
  input  logic [BYTE_W-1:0]     cnt_byte_i,
  output logic [5:0]            cw_o,
  output pit_mode_e             mode_o,
  output pit_mode_e             new_mode_o,
  output logic                  bcd_o,
  output logic                  cw_wr_o,
  output logic                  cnt_wr_o,
  output logic [2*BYTE_W-1:0]   reload_o
);
  logic [5:0]          cw_q;
  logic [BYTE_W-1:0]   lsb_q;
  logic                hi_q;
  logic [2*BYTE_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw_q     <= '0;
      lsb_q    <= '0;
      hi_q     <= 1'b0;
      reload_q <= '0;
    end else if (cw_we_i) begin
      cw_q <= cw_i;
      hi_q <= 1'b0;
    end else if (cnt_we_i) begin
      if (!hi_q) begin
        lsb_q <= cnt_byte_i;
        hi_q  <= 1'b1;
      end else begin
        reload_q <= {cnt_byte_i, lsb_q};
        hi_q     <= 1'b0;
      end
    end
  end

  assign cw_o       = cw_q;
  assign mode_o     = norm_mode(cw_q[3:1]);
  assign new_mode_o = norm_mode(cw_i[3:1]);
  assign bcd_o      = cw_q[0];
  assign cw_wr_o    = cw_we_i;
  assign cnt_wr_o   = cnt_we_i & hi_q & ~cw_we_i;
  assign reload_o   = reload_q;

  AST_CW_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> (cw_o == $past(cw_i))); // R11
endmodule

// File: rtl/pit_dec.sv
module pit_dec #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_i,
  input  logic                bcd_i,
  output logic [4*DIGITS-1:0] dec_o,
  output logic                zero_o
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] brw;
  logic [W-1:0]      bcd_res;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    assign d = val_i[4*g +: 4];
    assign bcd_res[4*g +: 4] = brw[g] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
    if (g < DIGITS - 1) begin : g_brw
      assign brw[g+1] = brw[g] & (d == 4'd0);
    end
  end

  assign dec_o  = bcd_i ? bcd_res : val_i - {{(W-1){1'b0}}, 1'b1};
  assign zero_o = (dec_o == '0);
endmodule

// File: rtl/pit_half.sv
module pit_half #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] per_i,
  input  logic                bcd_i,
  output logic [4*DIGITS:0]   half_o
);
  localparam int W = 4 * DIGITS;

  logic [W:0] eff;
  logic [W:0] bcd_half;

  // zero stands for one more than the largest count
  assign eff         = {per_i == '0, per_i};
  assign bcd_half[W] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign bcd_half[4*g +: 4] = {1'b0, eff[4*g+1 +: 3]} + (eff[4*g+4] ? 4'd5 : 4'd0);
  end

  assign half_o = bcd_i ? bcd_half : (eff >> 1);
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              cw_we_i,
  input  logic [5:0]        cw_i,
  input  logic              cnt_we_i,
  input  logic [BYTE_W-1:0] cnt_byte_i,
  output logic              out_o,
  output logic [7:0]        status_o
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  pit_mode_e        mode, new_mode;
  logic [5:0]       cw_q;
  logic             bcd, cw_wr, cnt_wr;
  logic [CNT_W-1:0] reload, dec;
  logic             dec_zero;
  logic [CNT_W:0]   half;

  logic [CNT_W-1:0] cnt_q, per_q;
  logic             out_q, run_q, pend_q, armed_q, null_q, gate_q;
  logic             rise, above_half, strobe_mode, gated_mode;

  pit_cfg #(.BYTE_W(BYTE_W)) u_cfg (
    .clk_i, .rst_ni, .cw_we_i, .cw_i, .cnt_we_i, .cnt_byte_i,
    .cw_o(cw_q), .mode_o(mode), .new_mode_o(new_mode), .bcd_o(bcd),
    .cw_wr_o(cw_wr), .cnt_wr_o(cnt_wr), .reload_o(reload)
  );

  pit_dec #(.DIGITS(DIGITS)) u_dec (
    .val_i(cnt_q), .bcd_i(bcd), .dec_o(dec), .zero_o(dec_zero)
  );

  pit_half #(.DIGITS(DIGITS)) u_half (
    .per_i(per_q), .bcd_i(bcd), .half_o(half)
  );

  assign rise        = gate_i & ~gate_q;
  assign above_half  = {dec_zero, dec} > half;
  assign strobe_mode = (mode == M_SWSTB) || (mode == M_HWSTB);
  assign gated_mode  = (mode == M_TCNT) || (mode == M_RATE) ||
                       (mode == M_SQUARE) || (mode == M_SWSTB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      null_q  <= 1'b0;
      gate_q  <= 1'b1;
    end else begin
      gate_q <= gate_i;
      if (cw_wr) begin
        out_q   <= (new_mode != M_TCNT);
        run_q   <= 1'b0;
        pend_q  <= 1'b0;
        armed_q <= 1'b0;
        null_q  <= 1'b0;
      end else begin
        if (cnt_wr) null_q <= 1'b1;
        // strobes last a single clock
        if (!out_q && strobe_mode) out_q <= 1'b1;
        case (mode)
          M_TCNT, M_SWSTB: begin
            if (cnt_wr) begin
              pend_q <= 1'b1;
              run_q  <= 1'b0;
              out_q  <= (mode == M_SWSTB);
            end else if (pend_q) begin
              cnt_q  <= reload;
              pend_q <= 1'b0;
              run_q  <= 1'b1;
              null_q <= 1'b0;
            end else if (run_q && gate_i) begin
              cnt_q <= dec;
              if (dec_zero) begin
                if (mode == M_TCNT) begin
                  out_q <= 1'b1;
                end else begin
                  out_q <= 1'b0;
                  run_q <= 1'b0;
                end
              end
            end
          end
          M_RATE, M_SQUARE: begin
            if (cnt_wr && !run_q) pend_q <= 1'b1;
            if (pend_q) begin
              cnt_q  <= reload;
              per_q  <= reload;
              run_q  <= 1'b1;
              pend_q <= 1'b0;
              null_q <= 1'b0;
              out_q  <= 1'b1;
            end else if (run_q && gate_i) begin
              if (dec_zero) begin
                cnt_q  <= reload;
                per_q  <= reload;
                null_q <= 1'b0;
                out_q  <= (mode == M_SQUARE);
              end else begin
                cnt_q <= dec;
                out_q <= (mode == M_RATE) | above_half;
              end
            end
          end
          M_ONESHOT, M_HWSTB: begin
            if (cnt_wr) armed_q <= 1'b1;
            if (rise && armed_q) begin
              cnt_q  <= reload;
              run_q  <= 1'b1;
              null_q <= 1'b0;
              out_q  <= (mode == M_HWSTB);
            end else if (run_q) begin
              cnt_q <= dec;
              if (dec_zero) begin
                run_q <= 1'b0;
                out_q <= (mode == M_ONESHOT);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign out_o    = out_q;
  assign status_o = {out_q, null_q, cw_q};

  AST_TC_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_TCNT && out_q && !cw_we_i && !cnt_wr) |=> out_q); // R1

  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_mode && run_q && !pend_q && !gate_i && !cw_we_i && !cnt_wr) |=> $stable(cnt_q)); // R2

  AST_RATE_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_RATE && !out_q && gate_i && !cw_we_i && per_q != 16'd1) |=> out_q); // R4

  AST_STROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_mode && !out_q && !cw_we_i) |=> out_q); // R6
endmodule

// File: tb/sim_pit_chan.sv
module sim_pit_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b1;
  logic       cw_we = 1'b0;
  logic [5:0] cw_v = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_b = '0;
  logic       out;
  logic [7:0] status;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .cw_we_i(cw_we), .cw_i(cw_v),
    .cnt_we_i(cnt_we), .cnt_byte_i(cnt_b), .out_o(out), .status_o(status)
  );

  // monitor: compare OUT against scheduled expectations
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      e = sb_q.pop_front();
      n_chk++;
      if (out !== e.val) begin
        n_bad++;
        $display("FAIL %s: out=%b expected %b at cycle %0d", e.tag, out, e.val, cyc);
      end
    end
  end

  task automatic exp_out(input int c, input logic v, input string t);
    sb_q.push_back('{c, v, t});
  endtask

  task automatic chk8(input string t, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: status=%h expected %h", t, act, expv);
    end
  endtask

  task automatic wr_cw(input logic [5:0] b);
    @(negedge clk); cw_we = 1'b1; cw_v = b;
    @(negedge clk); cw_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v, output int e0);
    @(negedge clk); cnt_we = 1'b1; cnt_b = v[7:0];
    @(negedge clk); cnt_b = v[15:8];
    @(negedge clk); cnt_we = 1'b0;
    e0 = cyc;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, cycle %0d expected below 190000", cyc);
    finish_run();
  end

  initial begin
    int e0, r, tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk8("R11 reset", status, 8'h00);

    // R1 / R11: terminal count, binary N=5
    wr_cw(6'h30);
    wr_cnt(16'd5, e0);
    chk8("R11 pending", status, 8'h70);
    exp_out(e0 + 5, 1'b0, "R1 before tc");
    exp_out(e0 + 6, 1'b1, "R1 at tc");
    exp_out(e0 + 20, 1'b1, "R1 stays high");
    wait_cyc(e0 + 21);
    chk8("R11 loaded", status, 8'hB0);

    // R2: gate low freezes count; R1 new count drops OUT
    wr_cnt(16'd6, e0);
    exp_out(e0 + 1, 1'b0, "R1 new count");
    exp_out(e0 + 7, 1'b0, "R2 frozen");
    exp_out(e0 + 10, 1'b0, "R2 before tc");
    exp_out(e0 + 11, 1'b1, "R2 resumed tc");
    wait_cyc(e0 + 2); gate = 1'b0;
    wait_cyc(e0 + 6); gate = 1'b1;
    wait_cyc(e0 + 12);

    // R4: rate generator N=4
    wr_cw(6'h34);
    wr_cnt(16'd4, e0);
    exp_out(e0 + 4, 1'b1, "R4 high");
    exp_out(e0 + 5, 1'b0, "R4 low");
    exp_out(e0 + 6, 1'b1, "R4 one clock");
    exp_out(e0 + 8, 1'b1, "R4 high 2");
    exp_out(e0 + 9, 1'b0, "R4 period");
    exp_out(e0 + 10, 1'b1, "R4 one clock 2");
    wait_cyc(e0 + 11);

    // R8: code 6 acts as rate generator
    wr_cw(6'h3C);
    chk8("R11 raw echo", status, 8'hBC);
    wr_cnt(16'd3, e0);
    exp_out(e0 + 3, 1'b1, "R8 alias6 high");
    exp_out(e0 + 4, 1'b0, "R8 alias6 low");
    exp_out(e0 + 5, 1'b1, "R8 alias6 back");
    exp_out(e0 + 7, 1'b0, "R8 alias6 period");
    exp_out(e0 + 8, 1'b1, "R8 alias6 back 2");
    wait_cyc(e0 + 9);

    // R5: square wave, odd N=5
    wr_cw(6'h36);
    wr_cnt(16'd5, e0);
    exp_out(e0 + 3, 1'b1, "R5 odd high3");
    exp_out(e0 + 4, 1'b0, "R5 odd low1");
    exp_out(e0 + 5, 1'b0, "R5 odd low2");
    exp_out(e0 + 6, 1'b1, "R5 odd rehigh");
    exp_out(e0 + 8, 1'b1, "R5 odd high3 b");
    exp_out(e0 + 9, 1'b0, "R5 odd low1 b");
    exp_out(e0 + 10, 1'b0, "R5 odd low2 b");
    exp_out(e0 + 11, 1'b1, "R5 odd rehigh b");
    wait_cyc(e0 + 12);

    // R5 / R8: code 7 square wave, even N=4
    wr_cw(6'h3E);
    wr_cnt(16'd4, e0);
    exp_out(e0 + 2, 1'b1, "R8 alias7 high");
    exp_out(e0 + 3, 1'b0, "R8 alias7 low");
    exp_out(e0 + 4, 1'b0, "R5 even low2");
    exp_out(e0 + 5, 1'b1, "R5 even rehigh");
    wait_cyc(e0 + 6);

    // R5 / R9: decimal square wave N=10
    wr_cw(6'h37);
    wr_cnt(16'h0010, e0);
    exp_out(e0 + 5, 1'b1, "R9 sq high5");
    exp_out(e0 + 6, 1'b0, "R9 sq low");
    exp_out(e0 + 10, 1'b0, "R9 sq low5");
    exp_out(e0 + 11, 1'b1, "R9 sq period");
    wait_cyc(e0 + 12);

    // R6: software strobe N=3
    wr_cw(6'h38);
    wr_cnt(16'd3, e0);
    exp_out(e0 + 3, 1'b1, "R6 before");
    exp_out(e0 + 4, 1'b0, "R6 strobe");
    exp_out(e0 + 5, 1'b1, "R6 one clock");
    exp_out(e0 + 15, 1'b1, "R6 single");
    wait_cyc(e0 + 16);

    // R7: hardware strobe N=3
    wr_cw(6'h3A);
    gate = 1'b0;
    wr_cnt(16'd3, e0);
    exp_out(e0 + 3, 1'b1, "R7 waits for gate");
    wait_cyc(e0 + 4);
    gate = 1'b1; r = cyc + 1;
    exp_out(r + 2, 1'b1, "R7 before");
    exp_out(r + 3, 1'b0, "R7 strobe");
    exp_out(r + 4, 1'b1, "R7 one clock");
    exp_out(r + 12, 1'b1, "R7 no repeat");
    wait_cyc(r + 5); gate = 1'b0;
    wait_cyc(r + 13);
    gate = 1'b1; r = cyc + 1;
    exp_out(r + 3, 1'b0, "R7 second trigger");
    exp_out(r + 4, 1'b1, "R7 second end");
    wait_cyc(r + 6);

    // R3: one-shot N=4
    gate = 1'b0;
    wr_cw(6'h32);
    wr_cnt(16'd4, e0);
    exp_out(e0 + 2, 1'b1, "R3 armed high");
    wait_cyc(e0 + 3);
    gate = 1'b1; r = cyc + 1;
    exp_out(r, 1'b0, "R3 start");
    exp_out(r + 3, 1'b0, "R3 low");
    exp_out(r + 4, 1'b1, "R3 end");
    wait_cyc(r + 6);
    // R3 retrigger
    gate = 1'b0; wait_cyc(cyc + 2);
    gate = 1'b1; r = cyc + 1;
    exp_out(r, 1'b0, "R3 start 2");
    exp_out(r + 4, 1'b0, "R3 retrigger extends");
    exp_out(r + 7, 1'b0, "R3 retrigger low");
    exp_out(r + 8, 1'b1, "R3 retrigger end");
    wait_cyc(r + 2); gate = 1'b0;
    wait_cyc(r + 3); gate = 1'b1;
    wait_cyc(r + 10);
    // R3 new count during pulse
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; r = cyc + 1;
    exp_out(r, 1'b0, "R3 start 3");
    exp_out(r + 3, 1'b0, "R3 pulse kept");
    exp_out(r + 4, 1'b1, "R3 new count no effect");
    wait_cyc(r);
    wr_cnt(16'd7, tmp);
    wait_cyc(r + 6);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; r = cyc + 1;
    exp_out(r + 6, 1'b0, "R3 new count used");
    exp_out(r + 7, 1'b1, "R3 new count end");
    wait_cyc(r + 9);

    // R9: decimal terminal count
    wr_cw(6'h31);
    wr_cnt(16'h0012, e0);
    exp_out(e0 + 12, 1'b0, "R9 12 before");
    exp_out(e0 + 13, 1'b1, "R9 12 tc");
    wait_cyc(e0 + 14);
    wr_cnt(16'h0100, e0);
    exp_out(e0 + 1, 1'b0, "R9 reload low");
    exp_out(e0 + 100, 1'b0, "R9 100 before");
    exp_out(e0 + 101, 1'b1, "R9 100 tc");
    wait_cyc(e0 + 102);
    wr_cnt(16'h0000, e0);
    exp_out(e0 + 10000, 1'b0, "R9 zero before");
    exp_out(e0 + 10001, 1'b1, "R9 zero is 10000");
    wait_cyc(e0 + 10002);

    // R10: binary zero counts 65536
    wr_cw(6'h30);
    wr_cnt(16'h0000, e0);
    exp_out(e0 + 65536, 1'b0, "R10 before");
    exp_out(e0 + 65537, 1'b1, "R10 zero is 65536");
    wait_cyc(e0 + 65538);

    // R12: control write resets the byte pointer
    @(negedge clk); cnt_we = 1'b1; cnt_b = 8'h55;
    @(negedge clk); cnt_we = 1'b0;
    wr_cw(6'h30);
    wr_cnt(16'd3, e0);
    exp_out(e0 + 3, 1'b0, "R12 ptr reset before");
    exp_out(e0 + 4, 1'b1, "R12 ptr reset tc");
    wait_cyc(e0 + 5);
    // R12: count byte alongside a control write is dropped
    @(negedge clk); cw_we = 1'b1; cw_v = 6'h30; cnt_we = 1'b1; cnt_b = 8'h09;
    @(negedge clk); cw_we = 1'b0; cnt_we = 1'b0;
    wr_cnt(16'd2, e0);
    exp_out(e0 + 2, 1'b0, "R12 collide before");
    exp_out(e0 + 3, 1'b1, "R12 collide tc");
    wait_cyc(e0 + 4);

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule